// File: doc/BRIEF.md
# Load String Immediate Sequencer

This block carries out a load-string-immediate operation over several cycles. A single start pulse brings in four operands: a target register index, a flag that marks the base register field as zero, the base register value and a 5-bit immediate byte count. From these the block forms a start address and a byte count. It then fetches bytes one at a time through a byte-wide memory read port that uses a request/valid handshake.

The fetched bytes are packed big-endian into 32-bit words. Each finished word goes out on a single register-file write port. Successive words go to successive register indices, and the index wraps from 31 back to 0.

A one-cycle done pulse follows the last write. The block is meant to sit beside an execution pipeline that owns the register file and the data memory. Decode, faults and condition flags stay outside it.

Top module: `lsi_seq`

## Requirements
- R1: The start address is 0 when `op_base_zero` is 1; otherwise it is `op_base_val`. The first `mem_addr` presented with `mem_req` equals that address.
- R2: The byte count is `op_imm` when that is nonzero, and 32 when `op_imm` is 0. Exactly that many memory handshakes (`mem_req` and `mem_vld` high together) take place per operation.
- R3: The bytes are read from consecutive ascending addresses, one per handshake. The 32-bit address wraps naturally, so 0xFFFFFFFF is followed by 0x00000000.
- R4: Within a word, the byte from the lowest address lands in `rf_wdata[31:24]`, the next in `[23:16]`, then `[15:8]`, then `[7:0]`.
- R5: In a last word that receives fewer than four bytes, every byte lane after the final loaded byte reads as zero.
- R6: The number of register writes is the byte count divided by 4, rounded up. The first write goes to `op_rt`, and each later write goes to the previous index plus 1 modulo 32.
- R7: `rf_we` is high for exactly one cycle per word, and it never stays high for two consecutive cycles.
- R8: While `mem_req` is high and `mem_vld` is low, the next cycle keeps `mem_req` high and `mem_addr` unchanged. A byte is consumed only in a cycle where `mem_vld` is high.
- R9: A `start` pulse that arrives while `busy` is high has no effect on the running operation, on its writes or on its reads. A `start` pulse in the done cycle does not begin a new operation.
- R10: `busy` rises in the cycle after an accepted `start` and stays high through the done cycle. `done` is high for exactly one cycle, in the cycle right after the last `rf_we`.
- R11: During and after a synchronous reset, the block is idle: `busy`, `done`, `mem_req` and `rf_we` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Operation request, sampled while idle |
| op_rt | input | 5 | First target register index |
| op_base_zero | input | 1 | 1 forces the start address to 0 |
| op_base_val | input | 32 | Base register value |
| op_imm | input | 5 | Immediate byte count, 0 meaning 32 |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| mem_req | output | 1 | Byte read request |
| mem_addr | output | 32 | Byte read address |
| mem_vld | input | 1 | Read data valid for the current request |
| mem_rdata | input | 8 | Read data byte |
| rf_we | output | 1 | Register write strobe |
| rf_widx | output | 5 | Register write index |
| rf_wdata | output | 32 | Register write data |

## Verification
Word completion and count exhaustion can fall on the same byte. This happens when the count is a multiple of four: a single handshake then both fills lane 3 and empties the count. The design must produce one write and then go to done, with no trailing zero word.

The bench provokes this with counts of 4, 8 and 32 under several memory latencies. It judges the result by the number of writes, their indices, and a done pulse that comes right after the last write.

A second collision is a new start arriving while the block is busy or in its done cycle. The bench checks that the running operation's reads and writes are unchanged and that the block returns to idle with no request.

// File: rtl/lsi_pkg.sv
package lsi_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WRITE = 2'd2,
    ST_DONE  = 2'd3
  } lsi_state_e;

endpackage

// File: rtl/lsi_addr_gen.sv
module lsi_addr_gen #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              load_zero,
  input  logic [ADDR_W-1:0] load_val,
  input  logic              step,
  output logic [ADDR_W-1:0] addr_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
    end else if (load) begin
      addr_q <= load_zero ? '0 : load_val;
    end else if (step) begin
      addr_q <= addr_q + ADDR_W'(1);
    end
  end

endmodule

// File: rtl/lsi_byte_packer.sv
module lsi_byte_packer #(
  parameter int WORD_W = 32,
  parameter int BYTE_W = 8,
  localparam int LANES  = WORD_W / BYTE_W,
  localparam int LANE_W = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              take,
  input  logic [LANE_W-1:0] lane,
  input  logic [BYTE_W-1:0] byte_in,
  output logic [WORD_W-1:0] word_q
);

  logic [BYTE_W-1:0] lane_q [LANES];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst) begin
        lane_q[g] <= '0;
      end else if (take) begin
        if (lane == LANE_W'(g)) begin
          lane_q[g] <= byte_in;
        end else if (lane == '0) begin
          lane_q[g] <= '0;
        end
      end
    end
    assign word_q[WORD_W-1-g*BYTE_W -: BYTE_W] = lane_q[g];
  end

endmodule

// File: rtl/lsi_ctrl.sv
module lsi_ctrl
  import lsi_pkg::*;
#(
  parameter int IDX_W  = 5,
  parameter int CNT_W  = 5,
  parameter int LANES  = 4,
  localparam int LANE_W = (LANES > 1) ? $clog2(LANES) : 1,
  localparam int REM_W  = CNT_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [IDX_W-1:0]  start_rt,
  input  logic [CNT_W-1:0]  start_imm,
  input  logic              mem_vld,
  output lsi_state_e        state_q,
  output logic [LANE_W-1:0] lane_q,
  output logic [IDX_W-1:0]  idx_q,
  output logic              accept,
  output logic              take
);

  localparam logic [REM_W-1:0]  FULL_CNT  = REM_W'(1) << CNT_W;
  localparam logic [LANE_W-1:0] LAST_LANE = LANE_W'(LANES - 1);

  logic [REM_W-1:0] rem_q;
  logic             word_full;
  logic             last_byte;

  assign accept    = (state_q == ST_IDLE) && start;
  assign take      = (state_q == ST_READ) && mem_vld;
  assign word_full = (lane_q == LAST_LANE);
  assign last_byte = (rem_q == REM_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      rem_q   <= '0;
      lane_q  <= '0;
      idx_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (start) begin
            rem_q   <= (start_imm == '0) ? FULL_CNT : REM_W'(start_imm);
            idx_q   <= start_rt;
            lane_q  <= '0;
            state_q <= ST_READ;
          end
        end
        ST_READ: begin
          if (mem_vld) begin
            rem_q  <= rem_q - REM_W'(1);
            lane_q <= lane_q + LANE_W'(1);
            if (word_full || last_byte) begin
              state_q <= ST_WRITE;
            end
          end
        end
        ST_WRITE: begin
          idx_q   <= idx_q + IDX_W'(1);
          lane_q  <= '0;
          state_q <= (rem_q == '0) ? ST_DONE : ST_READ;
        end
        ST_DONE: begin
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/lsi_seq.sv
module lsi_seq
  import lsi_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int WORD_W = 32,
  parameter int BYTE_W = 8,
  parameter int IDX_W  = 5,
  parameter int CNT_W  = 5,
  localparam int LANES  = WORD_W / BYTE_W,
  localparam int LANE_W = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [IDX_W-1:0]  op_rt,
  input  logic              op_base_zero,
  input  logic [ADDR_W-1:0] op_base_val,
  input  logic [CNT_W-1:0]  op_imm,
  output logic              busy,
  output logic              done,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_vld,
  input  logic [BYTE_W-1:0] mem_rdata,
  output logic              rf_we,
  output logic [IDX_W-1:0]  rf_widx,
  output logic [WORD_W-1:0] rf_wdata
);

  lsi_state_e        state_q;
  logic [LANE_W-1:0] lane_q;
  logic [IDX_W-1:0]  idx_q;
  logic              accept;
  logic              take;
  logic [ADDR_W-1:0] addr_q;
  logic [WORD_W-1:0] word_q;

  lsi_ctrl #(
    .IDX_W (IDX_W),
    .CNT_W (CNT_W),
    .LANES (LANES)
  ) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .start_rt  (op_rt),
    .start_imm (op_imm),
    .mem_vld   (mem_vld),
    .state_q   (state_q),
    .lane_q    (lane_q),
    .idx_q     (idx_q),
    .accept    (accept),
    .take      (take)
  );

  lsi_addr_gen #(
    .ADDR_W (ADDR_W)
  ) u_addr (
    .clk       (clk),
    .rst       (rst),
    .load      (accept),
    .load_zero (op_base_zero),
    .load_val  (op_base_val),
    .step      (take),
    .addr_q    (addr_q)
  );

  lsi_byte_packer #(
    .WORD_W (WORD_W),
    .BYTE_W (BYTE_W)
  ) u_pack (
    .clk     (clk),
    .rst     (rst),
    .take    (take),
    .lane    (lane_q),
    .byte_in (mem_rdata),
    .word_q  (word_q)
  );

  assign busy     = (state_q != ST_IDLE);
  assign done     = (state_q == ST_DONE);
  assign mem_req  = (state_q == ST_READ);
  assign mem_addr = addr_q;
  assign rf_we    = (state_q == ST_WRITE);
  assign rf_widx  = idx_q;
  assign rf_wdata = word_q;

endmodule

// File: rtl/lsi_seq_chk.sv
module lsi_seq_chk #(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic              mem_req,
  input logic              mem_vld,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              rf_we,
  input logic [IDX_W-1:0]  rf_widx
);

  logic             have_prev;
  logic [IDX_W-1:0] prev_idx;

  always_ff @(posedge clk) begin
    if (rst || done) begin
      have_prev <= 1'b0;
      prev_idx  <= '0;
    end else if (rf_we) begin
      have_prev <= 1'b1;
      prev_idx  <= rf_widx;
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_vld) |=> (mem_req && $stable(mem_addr))); // R8

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_vld) |=> (!mem_req || (mem_addr == $past(mem_addr) + ADDR_W'(1)))); // R3

  AST_WE_PULSE: assert property (@(posedge clk) disable iff (rst)
    rf_we |=> !rf_we); // R7

  AST_IDX_STEP: assert property (@(posedge clk) disable iff (rst)
    (rf_we && have_prev) |-> (rf_widx == prev_idx + IDX_W'(1))); // R6

  AST_DONE_AFTER_WE: assert property (@(posedge clk) disable iff (rst)
    done |-> ($past(rf_we) && busy)); // R10

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R10

  AST_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (busy && !done && start) |=> busy); // R9

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!mem_req && !rf_we && !done)); // R11

endmodule

bind lsi_seq lsi_seq_chk #(
  .ADDR_W (ADDR_W),
  .IDX_W  (IDX_W)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .start    (start),
  .busy     (busy),
  .done     (done),
  .mem_req  (mem_req),
  .mem_vld  (mem_vld),
  .mem_addr (mem_addr),
  .rf_we    (rf_we),
  .rf_widx  (rf_widx)
);

// File: tb/test_lsi_seq.sv
module test_lsi_seq;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 8;

  // {rt[44:40], base_zero[39], base_val[38:7], imm[6:2], latency[1:0]}
  localparam logic [44:0] VEC [NVEC] = '{
    {5'd0,  1'b1, 32'h0000_0000, 5'd4,  2'd0},
    {5'd3,  1'b0, 32'h0000_1000, 5'd0,  2'd0},
    {5'd30, 1'b0, 32'h0000_0200, 5'd0,  2'd1},
    {5'd10, 1'b0, 32'hFFFF_FFFE, 5'd5,  2'd0},
    {5'd31, 1'b0, 32'h0000_0055, 5'd1,  2'd2},
    {5'd5,  1'b1, 32'h0000_DEAD, 5'd7,  2'd1},
    {5'd20, 1'b0, 32'h1234_5679, 5'd8,  2'd3},
    {5'd12, 1'b0, 32'h0000_0040, 5'd31, 2'd0}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [4:0]  op_rt = '0;
  logic        op_base_zero = 1'b0;
  logic [31:0] op_base_val = '0;
  logic [4:0]  op_imm = '0;
  logic        busy, done, mem_req, rf_we;
  logic [31:0] mem_addr, rf_wdata;
  logic [4:0]  rf_widx;
  logic        mem_vld = 1'b0;
  logic [7:0]  mem_rdata = '0;

  int checks = 0;
  int errors = 0;
  int mem_lat = 0;
  int n_rd = 0;
  logic [31:0] rd_log [40];

  always #(CLK_PERIOD/2) clk = ~clk;

  lsi_seq i_lsi_seq (
    .clk          (clk),
    .rst          (rst),
    .start        (start),
    .op_rt        (op_rt),
    .op_base_zero (op_base_zero),
    .op_base_val  (op_base_val),
    .op_imm       (op_imm),
    .busy         (busy),
    .done         (done),
    .mem_req      (mem_req),
    .mem_addr     (mem_addr),
    .mem_vld      (mem_vld),
    .mem_rdata    (mem_rdata),
    .rf_we        (rf_we),
    .rf_widx      (rf_widx),
    .rf_wdata     (rf_wdata)
  );

  function automatic logic [7:0] mem_byte(input logic [31:0] a);
    return a[7:0] ^ {a[12:8], a[15:13]} ^ a[31:24] ^ 8'hA7;
  endfunction

  function automatic logic [31:0] exp_word(input logic [31:0] ea, input int cnt, input int k);
    logic [31:0] w = '0;
    for (int j = 0; j < 4; j++) begin
      if (4*k + j < cnt) w[31-8*j -: 8] = mem_byte(ea + 32'(4*k + j));
    end
    return w;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h at %0t", tag, act, exp, $time);
    end
  endtask

  // Memory model: answers a held request after mem_lat idle cycles.
  int wcnt = 0;
  always @(negedge clk) begin
    if (!busy) begin
      n_rd = 0;
    end
    if (mem_req) begin
      if (wcnt < mem_lat) begin
        mem_vld <= 1'b0;
        wcnt = wcnt + 1;
      end else begin
        mem_vld   <= 1'b1;
        mem_rdata <= mem_byte(mem_addr);
        if (n_rd < 40) rd_log[n_rd] = mem_addr;
        n_rd = n_rd + 1;
        wcnt = 0;
      end
    end else begin
      mem_vld <= 1'b0;
      wcnt = 0;
    end
  end

  task automatic run_op(input logic [4:0] rt, input logic bz, input logic [31:0] bv,
                        input logic [4:0] imm, input int lat, input bit poke_busy,
                        input bit poke_done);
    logic [31:0] ea = bz ? 32'h0 : bv;
    int cnt = (imm == 0) ? 32 : int'(imm);
    int nw = (cnt + 3) / 4;
    int wrote = 0;
    bit prev_we = 1'b0;
    bit finished = 1'b0;
    bit addr_ok = 1'b1;
    mem_lat = lat;
    @(negedge clk);
    start = 1'b1; op_rt = rt; op_base_zero = bz; op_base_val = bv; op_imm = imm;
    @(negedge clk);
    start = 1'b0; op_rt = 5'd7; op_base_zero = 1'b0; op_base_val = 32'h0000_4321; op_imm = 5'd2;
    check(busy == 1'b1, "R10 busy after start", 32'(busy), 32'd1);
    for (int cyc = 0; cyc < 3000; cyc++) begin
      @(negedge clk);
      start = (poke_busy && cyc == 2);
      if (rf_we) begin
        check(rf_widx == 5'(32'(rt) + 32'(wrote)), "R6 write index",
              32'(rf_widx), 32'(5'(32'(rt) + 32'(wrote))));
        check(rf_wdata == exp_word(ea, cnt, wrote),
              (4*(wrote+1) > cnt) ? "R5 zero-filled last word" : "R4 packed word",
              rf_wdata, exp_word(ea, cnt, wrote));
        wrote++;
      end
      if (done) begin
        check(prev_we, "R10 done follows last write", 32'(prev_we), 32'd1);
        check(wrote == nw, "R6 write count", 32'(wrote), 32'(nw));
        check(n_rd == cnt, "R2 byte count", 32'(n_rd), 32'(cnt));
        check(rd_log[0] == ea, "R1 start address", rd_log[0], ea);
        for (int i = 1; i < cnt && i < 40; i++) begin
          if (rd_log[i] != ea + 32'(i)) addr_ok = 1'b0;
        end
        check(addr_ok, "R3 ascending addresses", 32'(addr_ok), 32'd1);
        if (poke_done) start = 1'b1;
        finished = 1'b1;
        break;
      end
      prev_we = rf_we;
    end
    if (!finished) check(1'b0, "R10 operation never completed", 32'd0, 32'd1);
    @(negedge clk);
    start = 1'b0;
    check(!busy && !done, "R10 idle after done", 32'(busy), 32'd0);
    @(negedge clk);
    if (poke_done) check(!mem_req && !busy, "R9 start in done cycle ignored", 32'(mem_req), 32'd0);
  endtask

  initial begin
    int cyc_wd = 0;
    forever begin
      @(posedge clk);
      cyc_wd++;
      if (cyc_wd > 150000) begin
        errors++;
        checks++;
        $display("FAIL watchdog: actual=%0d expected<150000 cycles", cyc_wd);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!busy && !done && !mem_req && !rf_we, "R11 quiet in reset",
          {28'd0, busy, done, mem_req, rf_we}, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    check(!busy && !done && !mem_req && !rf_we, "R11 idle after reset",
          {28'd0, busy, done, mem_req, rf_we}, 32'd0);

    for (int v = 0; v < NVEC; v++) begin
      run_op(VEC[v][44:40], VEC[v][39], VEC[v][38:7], VEC[v][6:2], int'(VEC[v][1:0]), 1'b0, 1'b0);
    end

    // R9: start while busy, and start in the done cycle
    run_op(5'd8, 1'b0, 32'h0000_0300, 5'd9, 0, 1'b1, 1'b0);
    run_op(5'd29, 1'b0, 32'h0000_0777, 5'd12, 1, 1'b0, 1'b1);

    // R11: reset in mid-operation returns to idle
    @(negedge clk);
    start = 1'b1; op_rt = 5'd1; op_base_zero = 1'b0; op_base_val = 32'h100; op_imm = 5'd16;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check(!busy && !mem_req && !rf_we && !done, "R11 reset mid-operation",
          {28'd0, busy, done, mem_req, rf_we}, 32'd0);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    check(!busy && !mem_req, "R11 stays idle", {30'd0, busy, mem_req}, 32'd0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule